// File: doc/BRIEF.md
# Stream-to-Memory Write DMA

This block takes 32-bit words from a valid/ready source, typically the read side of a sample FIFO, and writes them to memory in bursts. Each burst goes out through a request/acknowledge address phase that carries the address and the beat count. A data phase follows, and the memory side can stall each beat. Words are held in an internal buffer between the two sides, so the source can deliver words back-to-back while the memory side is busy.

Software programs a start address, a length in bytes, a burst size and a loop enable, and then pulses a start strobe. The engine writes the region once and then raises a done flag. In loop mode it rewrites the region as a circular buffer and never raises done, and software follows progress by reading the current write address. A soft reset discards buffered words, returns the engine to idle and sets done. The done flag then stays set until the next accepted start, whether or not a transfer is requested.

Top module: `dma_wr_engine`

## Requirements
- R1: After the asynchronous reset, done_o is 1, cur_addr_o is 0, in_ready_o is 1 and neither mem_req_o nor mem_wvalid_o is asserted.
- R2: A cycle with soft_rst_i high discards every buffered word and holds in_ready_o low. On the next cycle done_o is 1, cur_addr_o is 0 and no request or beat is asserted. done_o then stays 1 for as long as no start is accepted.
- R3: done_o falls only on the cycle after an accepted start_i. A start_i that arrives while a transfer is running (done_o is 0) is ignored and is not queued.
- R4: Every input word accepted (in_valid_i and in_ready_o both high) is written exactly once and in arrival order. in_ready_o is low only while the buffer holds DEPTH words, so words can be accepted on consecutive cycles.
- R5: mem_req_o is raised only when the buffer holds at least the beat count of the burst. mem_addr_o and mem_len_o stay stable until mem_ack_i.
- R6: Each burst length is the minimum of the effective burst size and the remaining word count. A burst_i of 0 is treated as 1, and a value above MAX_BURST is treated as MAX_BURST. Burst addresses advance by 4 bytes per word written.
- R7: A burst carries exactly mem_len_o beats. mem_wdata_o is held while mem_wvalid_o is high and mem_wready_i is low, for any burst size.
- R8: In single-pass mode, done_o rises after the last beat, and cur_addr_o then equals the start address plus 4 times the word count.
- R9: In loop mode, the next burst after the end of the region starts again at the start address, and done_o never rises.
- R10: cur_addr_o is loaded with the start address on an accepted start. It advances only after a whole burst, so at each address acknowledge it equals mem_addr_o.
- R11: The word count is len_bytes_i divided by 4, and the two low bits are ignored. A start with a word count of zero is ignored and done_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset |
| start_i | input | 1 | Start strobe |
| base_addr_i | input | ADDR_W | Start byte address |
| len_bytes_i | input | LEN_W | Transfer length in bytes |
| burst_i | input | BURST_W | Burst size in words |
| loop_i | input | 1 | Circular buffer enable |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Input word |
| in_ready_o | output | 1 | Input word accepted |
| mem_req_o | output | 1 | Burst address request |
| mem_ack_i | input | 1 | Burst address acknowledge |
| mem_addr_o | output | ADDR_W | Burst start byte address |
| mem_len_o | output | BURST_W | Burst beat count |
| mem_wvalid_o | output | 1 | Write beat valid |
| mem_wready_i | input | 1 | Write beat accepted |
| mem_wdata_o | output | 32 | Write beat data |
| done_o | output | 1 | Transfer done flag |
| cur_addr_o | output | ADDR_W | Current write address |

## Verification
The bench goes after the done flag right after a soft reset and through a long idle stretch. A design that clears done whenever no transfer is pending would read 0 there. It streams a 352-word transfer with the input valid on every cycle. Dropped or repeated words would show up as a data mismatch against the ordered scoreboard or a wrong ready level. Uneven lengths, a zero burst size and an oversized burst size check the shortened last burst and the clamping. Random stalls on the memory side under multi-beat bursts expose lost beats and data changing while a beat is stalled. A start issued mid-transfer and a loop run that wraps twice check that the extra start is not queued, that the write address returns to the start of the region, and that done never rises.

// File: rtl/dma_wr_pkg.sv
package dma_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA,
    ST_NEXT
  } wr_state_e;
endpackage

// File: rtl/dma_wr_fifo.sv
module dma_wr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/dma_wr_cfg.sv
module dma_wr_cfg #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 16,
  localparam int BURST_W  = $clog2(MAX_BURST + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  base_addr_i,
  input  logic [LEN_W-1:0]   len_bytes_i,
  input  logic [BURST_W-1:0] burst_i,
  input  logic               loop_i,
  output logic [LEN_W-1:0]   words_o,
  output logic [ADDR_W-1:0]  base_q_o,
  output logic [LEN_W-1:0]   total_q_o,
  output logic [BURST_W-1:0] burst_q_o,
  output logic               loop_q_o
);
  logic [BURST_W-1:0] burst_eff;

  assign words_o = len_bytes_i >> 2;

  // clamp to 1..MAX_BURST
  always_comb begin
    if (burst_i == '0)                          burst_eff = BURST_W'(1);
    else if (burst_i > BURST_W'(MAX_BURST))     burst_eff = BURST_W'(MAX_BURST);
    else                                        burst_eff = burst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q_o  <= '0;
      total_q_o <= '0;
      burst_q_o <= BURST_W'(1);
      loop_q_o  <= 1'b0;
    end else if (soft_rst_i) begin
      base_q_o  <= '0;
      total_q_o <= '0;
      burst_q_o <= BURST_W'(1);
      loop_q_o  <= 1'b0;
    end else if (load_i) begin
      base_q_o  <= base_addr_i;
      total_q_o <= words_o;
      burst_q_o <= burst_eff;
      loop_q_o  <= loop_i;
    end
  end
endmodule

// File: rtl/dma_wr_fsm.sv
module dma_wr_fsm
  import dma_wr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 16,
  parameter int DEPTH     = 32,
  localparam int BURST_W  = $clog2(MAX_BURST + 1),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int CMP_W    = (CNT_W > BURST_W) ? CNT_W : BURST_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   words_i,
  input  logic [ADDR_W-1:0]  base_raw_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [LEN_W-1:0]   total_i,
  input  logic [BURST_W-1:0] burst_i,
  input  logic               loop_i,
  input  logic [CNT_W-1:0]   fifo_cnt_i,
  input  logic               mem_ack_i,
  input  logic               mem_wready_i,
  output logic               load_o,
  output logic               pop_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [BURST_W-1:0] mem_len_o,
  output logic               mem_wvalid_o,
  output logic               done_o,
  output logic [ADDR_W-1:0]  cur_addr_o
);
  wr_state_e          state_q;
  logic [ADDR_W-1:0]  cur_q;
  logic [LEN_W-1:0]   rem_q, rem_after;
  logic [BURST_W-1:0] blen_q, beat_q, this_len;
  logic               done_q;

  always_comb begin
    if (rem_q < LEN_W'(burst_i)) this_len = rem_q[BURST_W-1:0];
    else                         this_len = burst_i;
  end

  assign rem_after    = rem_q - LEN_W'(blen_q);
  assign load_o       = start_i && !soft_rst_i && (state_q == ST_IDLE) && (words_i != '0);
  // buffer only grows while in REQ, so the request never drops before ack
  assign mem_req_o    = (state_q == ST_REQ) && (CMP_W'(fifo_cnt_i) >= CMP_W'(this_len));
  assign mem_addr_o   = cur_q;
  assign mem_len_o    = this_len;
  assign mem_wvalid_o = (state_q == ST_DATA);
  assign pop_o        = mem_wvalid_o && mem_wready_i;
  assign done_o       = done_q;
  assign cur_addr_o   = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
      blen_q  <= '0;
      beat_q  <= '0;
      done_q  <= 1'b1;
    end else if (soft_rst_i) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
      blen_q  <= '0;
      beat_q  <= '0;
      done_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load_o) begin
            state_q <= ST_REQ;
            done_q  <= 1'b0;
            cur_q   <= base_raw_i;
            rem_q   <= words_i;
          end
        end
        ST_REQ: begin
          if (mem_req_o && mem_ack_i) begin
            blen_q  <= this_len;
            beat_q  <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (pop_o) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == blen_q - 1'b1) state_q <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (rem_after == '0) begin
            if (loop_i) begin
              cur_q   <= base_i;
              rem_q   <= total_i;
              state_q <= ST_REQ;
            end else begin
              cur_q   <= cur_q + ADDR_W'({blen_q, 2'b00});
              rem_q   <= '0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else begin
            cur_q   <= cur_q + ADDR_W'({blen_q, 2'b00});
            rem_q   <= rem_after;
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_wr_engine.sv
module dma_wr_engine #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 16,
  parameter int DEPTH     = 32,
  localparam int BURST_W  = $clog2(MAX_BURST + 1),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  base_addr_i,
  input  logic [LEN_W-1:0]   len_bytes_i,
  input  logic [BURST_W-1:0] burst_i,
  input  logic               loop_i,
  input  logic               in_valid_i,
  input  logic [31:0]        in_data_i,
  output logic               in_ready_o,
  output logic               mem_req_o,
  input  logic               mem_ack_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [BURST_W-1:0] mem_len_o,
  output logic               mem_wvalid_o,
  input  logic               mem_wready_i,
  output logic [31:0]        mem_wdata_o,
  output logic               done_o,
  output logic [ADDR_W-1:0]  cur_addr_o
);
  logic               load, pop, push, full;
  logic [CNT_W-1:0]   fifo_cnt;
  logic [LEN_W-1:0]   words, total_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] burst_q;
  logic               loop_q;

  assign in_ready_o = !full && !soft_rst_i;
  assign push       = in_valid_i && in_ready_o;

  dma_wr_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (soft_rst_i),
    .push_i  (push),
    .wdata_i (in_data_i),
    .pop_i   (pop),
    .rdata_o (mem_wdata_o),
    .count_o (fifo_cnt),
    .full_o  (full)
  );

  dma_wr_cfg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .load_i      (load),
    .base_addr_i (base_addr_i),
    .len_bytes_i (len_bytes_i),
    .burst_i     (burst_i),
    .loop_i      (loop_i),
    .words_o     (words),
    .base_q_o    (base_q),
    .total_q_o   (total_q),
    .burst_q_o   (burst_q),
    .loop_q_o    (loop_q)
  );

  dma_wr_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .DEPTH(DEPTH)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .start_i      (start_i),
    .words_i      (words),
    .base_raw_i   (base_addr_i),
    .base_i       (base_q),
    .total_i      (total_q),
    .burst_i      (burst_q),
    .loop_i       (loop_q),
    .fifo_cnt_i   (fifo_cnt),
    .mem_ack_i    (mem_ack_i),
    .mem_wready_i (mem_wready_i),
    .load_o       (load),
    .pop_o        (pop),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_len_o    (mem_len_o),
    .mem_wvalid_o (mem_wvalid_o),
    .done_o       (done_o),
    .cur_addr_o   (cur_addr_o)
  );
endmodule

// File: rtl/dma_wr_engine_chk.sv
module dma_wr_engine_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 16,
  localparam int BURST_W  = $clog2(MAX_BURST + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               soft_rst_i,
  input logic               start_i,
  input logic               in_ready_o,
  input logic               mem_req_o,
  input logic               mem_ack_i,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic [BURST_W-1:0] mem_len_o,
  input logic               mem_wvalid_o,
  input logic               mem_wready_i,
  input logic [31:0]        mem_wdata_o,
  input logic               done_o
);
  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o));

  // R7
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    mem_wvalid_o && !mem_wready_i |=> mem_wvalid_o && $stable(mem_wdata_o));

  // R6
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_len_o != '0) && (mem_len_o <= BURST_W'(MAX_BURST)));

  // R2
  soft_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> done_o && !mem_req_o && !mem_wvalid_o);

  // R2
  soft_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |-> !in_ready_o);

  // R3
  done_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(start_i) && !$past(soft_rst_i));

  // R8
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o && !mem_wvalid_o);
endmodule

bind dma_wr_engine dma_wr_engine_chk #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .soft_rst_i   (soft_rst_i),
  .start_i      (start_i),
  .in_ready_o   (in_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_ack_i    (mem_ack_i),
  .mem_addr_o   (mem_addr_o),
  .mem_len_o    (mem_len_o),
  .mem_wvalid_o (mem_wvalid_o),
  .mem_wready_i (mem_wready_i),
  .mem_wdata_o  (mem_wdata_o),
  .done_o       (done_o)
);

// File: tb/dma_wr_engine_test.sv
`timescale 1ns/1ps
module dma_wr_engine_test;
  localparam int ADDR_W    = 32;
  localparam int LEN_W     = 16;
  localparam int MAX_BURST = 16;
  localparam int DEPTH     = 32;
  localparam int BURST_W   = $clog2(MAX_BURST + 1);

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               soft_rst_i = 1'b0;
  logic               start_i = 1'b0;
  logic [ADDR_W-1:0]  base_addr_i = '0;
  logic [LEN_W-1:0]   len_bytes_i = '0;
  logic [BURST_W-1:0] burst_i = '0;
  logic               loop_i = 1'b0;
  logic               in_valid_i = 1'b0;
  logic [31:0]        in_data_i = '0;
  logic               in_ready_o;
  logic               mem_req_o;
  logic               mem_ack_i = 1'b0;
  logic [ADDR_W-1:0]  mem_addr_o;
  logic [BURST_W-1:0] mem_len_o;
  logic               mem_wvalid_o;
  logic               mem_wready_i = 1'b0;
  logic [31:0]        mem_wdata_o;
  logic               done_o;
  logic [ADDR_W-1:0]  cur_addr_o;

  dma_wr_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .DEPTH(DEPTH)) uut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [31:0] exp_q[$];
  logic [31:0] word_ctr = 32'h1000_0000;
  int strm = 0, ack_pct = 100, rdy_pct = 100;
  bit pend_start = 0, pend_soft = 0;
  bit act = 0, m_loop = 0;
  logic [ADDR_W-1:0] m_base = '0, m_addr = '0;
  int m_total = 0, m_rem = 0, m_burst = 1, m_beats = 0, m_len = 0, m_wraps = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint actv, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, actv, expv);
    end
  endtask

  function automatic int eff_burst(input int b);
    if (b == 0) return 1;
    if (b > MAX_BURST) return MAX_BURST;
    return b;
  endfunction

  task automatic step();
    @(negedge clk_i);
    start_i    = pend_start;
    soft_rst_i = pend_soft;
    pend_start = 0;
    pend_soft  = 0;
    in_valid_i   = (strm == 1) || (strm == 2 && ($urandom % 3 != 0));
    in_data_i    = word_ctr;
    mem_ack_i    = !soft_rst_i && (($urandom % 100) < ack_pct);
    mem_wready_i = !soft_rst_i && (($urandom % 100) < rdy_pct);
    #1;
    cycles++;
    if (cycles > 150000) begin
      chk(0, "WD", "watchdog expired", cycles, 150000);
      summary();
    end
    if (soft_rst_i) begin
      exp_q.delete();
      act = 0;
      m_beats = 0;
    end else begin
      chk(in_ready_o == (exp_q.size() < DEPTH), "R4", "ready vs buffer fill", in_ready_o, exp_q.size() < DEPTH);
      if (act) chk(!done_o, m_loop ? "R9" : "R8", "done high during transfer", done_o, 0);
      if (mem_req_o && mem_ack_i) begin
        int l;
        l = (m_rem < m_burst) ? m_rem : m_burst;
        chk(act && m_beats == 0, "R5", "request outside transfer", act, 1);
        chk(mem_addr_o == m_addr, "R6", "burst address", mem_addr_o, m_addr);
        chk(int'(mem_len_o) == l, "R6", "burst length", mem_len_o, l);
        chk(cur_addr_o == m_addr, "R10", "cur_addr at acknowledge", cur_addr_o, m_addr);
        chk(exp_q.size() >= l, "R5", "request before words buffered", exp_q.size(), l);
        m_len = l;
        m_beats = l;
      end
      if (mem_wvalid_o && mem_wready_i) begin
        chk(m_beats > 0, "R7", "beat beyond burst length", m_beats, 1);
        if (exp_q.size() == 0) chk(0, "R4", "beat with no word accepted", mem_wdata_o, 0);
        else begin
          logic [31:0] w;
          w = exp_q.pop_front();
          chk(mem_wdata_o == w, "R4", "write data order", mem_wdata_o, w);
        end
        if (m_beats > 0) begin
          m_beats--;
          if (m_beats == 0) begin
            m_addr = m_addr + 32'(4 * m_len);
            m_rem  = m_rem - m_len;
            if (m_rem == 0) begin
              if (m_loop) begin
                m_addr = m_base;
                m_rem  = m_total;
                m_wraps++;
              end else act = 0;
            end
          end
        end
      end
      if (in_valid_i && in_ready_o) begin
        exp_q.push_back(in_data_i);
        word_ctr++;
      end
      if (start_i && done_o && (len_bytes_i >> 2) != 0) begin
        act     = 1;
        m_base  = base_addr_i;
        m_addr  = base_addr_i;
        m_total = int'(len_bytes_i >> 2);
        m_rem   = m_total;
        m_burst = eff_burst(int'(burst_i));
        m_loop  = loop_i;
        m_beats = 0;
        m_wraps = 0;
      end
    end
  endtask

  task automatic run_xfer(input logic [31:0] base, input int len, input int burst,
                          input int s, input int ap, input int rp, input string tag);
    int words;
    words = len / 4;
    base_addr_i = base;
    len_bytes_i = LEN_W'(len);
    burst_i     = BURST_W'(burst);
    loop_i      = 1'b0;
    strm = s; ack_pct = ap; rdy_pct = rp;
    pend_start = 1;
    step();
    step();
    chk(!done_o, "R3", "done cleared after start", done_o, 0);
    for (int i = 0; i < 20000 && !done_o; i++) step();
    chk(done_o, "R8", {tag, " done after transfer"}, done_o, 1);
    chk(cur_addr_o == base + 32'(4 * words), "R8", {tag, " final cur_addr"}, cur_addr_o, base + 32'(4 * words));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk(done_o == 1'b1, "R1", "done after reset", done_o, 1);
    chk(cur_addr_o == '0, "R1", "cur_addr after reset", cur_addr_o, 0);
    chk(in_ready_o == 1'b1, "R1", "ready after reset", in_ready_o, 1);
    chk(!mem_req_o && !mem_wvalid_o, "R1", "memory side quiet after reset", mem_req_o, 0);

    // R2 soft reset while idle with words buffered
    strm = 1;
    repeat (10) step();
    strm = 0;
    pend_soft = 1;
    step();
    step();
    chk(done_o, "R2", "done after soft reset", done_o, 1);
    chk(cur_addr_o == '0, "R2", "cur_addr after soft reset", cur_addr_o, 0);
    repeat (40) step();
    chk(done_o, "R2", "done stays set while idle", done_o, 1);

    // R4 full-rate 1408-byte transfer, large bursts
    run_xfer(32'h0001_0000, 1408, 16, 1, 100, 100, "full-rate");
    // R7 throttled memory side with multi-beat bursts
    run_xfer(32'h0002_0000, 1408, 8, 1, 40, 35, "throttled");
    // R11 low length bits ignored, short last burst (7,7,7,4)
    run_xfer(32'h0003_0000, 103, 7, 2, 70, 60, "R11 odd length");
    // R6 zero burst size acts as one, oversized burst clamps
    run_xfer(32'h0004_0000, 12, 0, 2, 80, 80, "R6 burst zero");
    run_xfer(32'h0004_1000, 200, 31, 1, 80, 80, "R6 burst clamp");

    // R11 zero-word start ignored
    len_bytes_i = 16'd3;
    ack_pct = 100;
    pend_start = 1;
    step();
    step();
    chk(done_o, "R11", "zero-word start ignored", done_o, 1);
    repeat (5) step();
    chk(!mem_req_o, "R11", "no request after zero-word start", mem_req_o, 0);

    // R3 start during active transfer is ignored
    base_addr_i = 32'h0005_0000; len_bytes_i = 16'd160; burst_i = 5'd8; loop_i = 1'b0;
    strm = 2; ack_pct = 60; rdy_pct = 60;
    pend_start = 1;
    step();
    repeat (10) step();
    base_addr_i = 32'h0009_0000; len_bytes_i = 16'd400;
    pend_start = 1;
    step();
    for (int i = 0; i < 5000 && !done_o; i++) step();
    chk(done_o, "R3", "first transfer finishes", done_o, 1);
    chk(cur_addr_o == 32'h0005_00A0, "R3", "second start not queued", cur_addr_o, 32'h0005_00A0);
    repeat (10) step();
    chk(done_o, "R3", "no queued transfer runs", done_o, 1);

    // R9 loop mode wraps, then soft reset mid-transfer
    base_addr_i = 32'h0006_0000; len_bytes_i = 16'd64; burst_i = 5'd4; loop_i = 1'b1;
    strm = 2; ack_pct = 70; rdy_pct = 70;
    pend_start = 1;
    step();
    for (int i = 0; i < 3000 && m_wraps < 2; i++) step();
    chk(m_wraps >= 2, "R9", "loop wrapped twice", m_wraps, 2);
    chk(!done_o, "R9", "done stays low in loop mode", done_o, 0);
    repeat (7) step();
    pend_soft = 1;
    step();
    step();
    chk(done_o, "R2", "done after soft reset mid-loop", done_o, 1);
    chk(!mem_req_o && !mem_wvalid_o, "R2", "memory side quiet after soft reset", mem_wvalid_o, 0);
    chk(cur_addr_o == '0, "R2", "cur_addr cleared mid-loop", cur_addr_o, 0);
    strm = 0;
    repeat (30) step();
    chk(done_o, "R2", "done held through idle after soft reset", done_o, 1);
    loop_i = 1'b0;

    // constrained random transfers
    for (int n = 0; n < 12; n++) begin
      run_xfer($urandom & 32'h0FFF_FFFC, int'($urandom % 600) + 4, int'($urandom % 20),
               1 + int'($urandom % 2), 30 + int'($urandom % 71), 20 + int'($urandom % 81), "random");
    end

    summary();
  end
endmodule